// File: doc/BRIEF.md
# Output-Port Virtual-Channel Credit Tracker

This block sits on one output port of a network-on-chip router and keeps, for every output virtual channel, whether the channel is owned by a packet (ACTIVE) or free (IDLE) and how many buffer slots remain in the matching input channel of the downstream router. The channels are divided into equal, contiguous groups, one group per virtual network.

A switch-allocation winner presents a virtual network number. It gets back, in the same cycle, whether a free channel exists in that group and the index of the lowest free one. The channel becomes ACTIVE at the next clock edge. Each flit sent on a channel spends one credit. The downstream router returns one credit per cycle. A returned credit may carry a release flag, and that flag hands the channel back to the free pool. A credit query port reports the count for any channel and whether it is nonzero.

Top module: `vc_credit_tracker`

## Requirements
- R1: After a synchronous active-low reset, every channel is IDLE (`vc_busy` all zero) and holds `BUF_DEPTH` credits.
- R2: `alloc_avail` is 1 exactly when at least one channel in the range `alloc_vnet*VCS_PER_VNET` to `alloc_vnet*VCS_PER_VNET+VCS_PER_VNET-1` is IDLE.
- R3: With `alloc_req` high and a free channel present, `alloc_grant` is 1 and `alloc_vc` names the lowest-index IDLE channel of that range. That channel is ACTIVE after the next edge.
- R4: With `alloc_req` high and no IDLE channel in the range, `alloc_grant` is 0 and no channel changes state.
- R5: A `send_valid` pulse lowers the credit count of `send_vc` by one at the next edge.
- R6: A `credit_valid` pulse raises the credit count of `credit_vc` by one at the next edge and leaves its state unchanged when `credit_free` is 0.
- R7: A credit with `credit_free` set also returns `credit_vc` to IDLE.
- R8: `cq_has_credit` is 1 exactly when the count of `cq_vc` (shown on `cq_credits`) is nonzero.
- R9: When a grant and a releasing credit name the same channel in one cycle, the release wins and the channel ends IDLE. The grant itself is computed from the state before the update.
- R10: A send and a credit return on the same channel in one cycle leave its count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 1 | Allocation request from the switch-allocation winner |
| alloc_vnet | input | VN_W | Virtual network of the request |
| alloc_avail | output | 1 | A free channel exists in the requested network |
| alloc_grant | output | 1 | The request is granted this cycle |
| alloc_vc | output | VC_W | Granted channel index |
| send_valid | input | 1 | A flit leaves on `send_vc` |
| send_vc | input | VC_W | Channel of the sent flit |
| credit_valid | input | 1 | A credit arrives from downstream |
| credit_vc | input | VC_W | Channel named by the credit |
| credit_free | input | 1 | The credit releases the channel |
| cq_vc | input | VC_W | Channel for the credit query |
| cq_credits | output | CNT_W | Credit count of `cq_vc` |
| cq_has_credit | output | 1 | `cq_vc` has at least one credit |
| vc_busy | output | NUM_VCS | Per-channel ACTIVE flag |

## Verification
Directed sequences first fill one virtual network's channels in order, which shows lowest-first selection and the point where the pool runs dry. They then drain one channel to zero credits and refill it with and without the release flag. Two same-cycle collisions are driven on purpose. A send and a credit on one channel tell apart a design that nets the count from one that drops an update. A grant and a release on one channel tell apart release priority from grant priority. Seeded random cycles then mix allocations, sends and credits over all networks, with each step kept legal by a bench model. This catches cross-talk between groups and index mistakes at group boundaries.

// File: rtl/vc_credit_pkg.sv
// Shared types for the output-port channel credit tracker.
package vc_credit_pkg;
    typedef enum logic {
        VC_IDLE   = 1'b0,
        VC_ACTIVE = 1'b1
    } vc_state_e;
endpackage

// File: rtl/vc_free_picker.sv
// Finds the lowest set bit of a free-channel mask for one virtual network.
// Assumes: purely combinational, mask width is VCS_PER_VNET.
module vc_free_picker #(
    parameter int VCS_PER_VNET = 4,
    localparam int LOC_W = (VCS_PER_VNET > 1) ? $clog2(VCS_PER_VNET) : 1
) (
    input  logic [VCS_PER_VNET-1:0] idle_i,
    output logic                    found_o,
    output logic [LOC_W-1:0]        idx_o
);
    // Priority scan from the top so the lowest index wins last.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = VCS_PER_VNET - 1; i >= 0; i--) begin
            if (idle_i[i]) begin
                found_o = 1'b1;
                idx_o   = LOC_W'(i);
            end
        end
    end
endmodule

// File: rtl/vc_credit_slot.sv
// State and credit counter for one output channel.
// Assumes: senders never spend a credit at zero and downstream never
// returns more than DEPTH credits. A release has priority over a take.
module vc_credit_slot
    import vc_credit_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic             send_i,
    input  logic             ret_i,
    input  logic             rel_i,
    output vc_state_e        state_o,
    output logic [CNT_W-1:0] cnt_o
);
    vc_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;

    // Ownership: a release beats a take in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      state_q <= VC_IDLE;
        else if (rel_i)  state_q <= VC_IDLE;
        else if (take_i) state_q <= VC_ACTIVE;
    end

    // Credit count: a send and a return together cancel out.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= CNT_W'(DEPTH);
        else begin
            case ({ret_i, send_i})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign state_o = state_q;
    assign cnt_o   = cnt_q;

    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        send_i && !ret_i |-> cnt_q != '0);
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ret_i && !send_i |-> cnt_q < CNT_W'(DEPTH));
    p_release_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rel_i |=> state_q == VC_IDLE);
    p_net_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ret_i && send_i |=> $stable(cnt_q));
endmodule

// File: rtl/vc_credit_tracker.sv
// Output-port channel credit tracker. Channels are grouped per virtual
// network; allocation grants the lowest free channel of a group in the
// same cycle and marks it ACTIVE at the edge. Credits from downstream
// arrive one per cycle and may release their channel.
// Assumes: alloc_vnet < NUM_VNETS when alloc_req is high.
module vc_credit_tracker
    import vc_credit_pkg::*;
#(
    parameter int NUM_VNETS    = 3,
    parameter int VCS_PER_VNET = 4,
    parameter int BUF_DEPTH    = 4,
    localparam int NUM_VCS = NUM_VNETS * VCS_PER_VNET,
    localparam int VC_W    = (NUM_VCS > 1) ? $clog2(NUM_VCS) : 1,
    localparam int VN_W    = (NUM_VNETS > 1) ? $clog2(NUM_VNETS) : 1,
    localparam int LOC_W   = (VCS_PER_VNET > 1) ? $clog2(VCS_PER_VNET) : 1,
    localparam int CNT_W   = $clog2(BUF_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_req,
    input  logic [VN_W-1:0]    alloc_vnet,
    output logic               alloc_avail,
    output logic               alloc_grant,
    output logic [VC_W-1:0]    alloc_vc,
    input  logic               send_valid,
    input  logic [VC_W-1:0]    send_vc,
    input  logic               credit_valid,
    input  logic [VC_W-1:0]    credit_vc,
    input  logic               credit_free,
    input  logic [VC_W-1:0]    cq_vc,
    output logic [CNT_W-1:0]   cq_credits,
    output logic               cq_has_credit,
    output logic [NUM_VCS-1:0] vc_busy
);
    vc_state_e        st   [NUM_VCS];
    logic [CNT_W-1:0] cnt  [NUM_VCS];
    logic [NUM_VCS-1:0] idle;
    logic [NUM_VNETS-1:0] grp_found;
    logic [LOC_W-1:0]     grp_idx [NUM_VNETS];

    // One slot per channel.
    for (genvar g = 0; g < NUM_VCS; g++) begin : g_slot
        vc_credit_slot #(.DEPTH(BUF_DEPTH)) slot_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .take_i  (alloc_grant && alloc_vc == VC_W'(g)),
            .send_i  (send_valid && send_vc == VC_W'(g)),
            .ret_i   (credit_valid && credit_vc == VC_W'(g)),
            .rel_i   (credit_valid && credit_free && credit_vc == VC_W'(g)),
            .state_o (st[g]),
            .cnt_o   (cnt[g])
        );
        assign idle[g]    = (st[g] == VC_IDLE);
        assign vc_busy[g] = (st[g] == VC_ACTIVE);
    end

    // One lowest-first picker per virtual network.
    for (genvar v = 0; v < NUM_VNETS; v++) begin : g_grp
        vc_free_picker #(.VCS_PER_VNET(VCS_PER_VNET)) pick_i (
            .idle_i  (idle[v*VCS_PER_VNET +: VCS_PER_VNET]),
            .found_o (grp_found[v]),
            .idx_o   (grp_idx[v])
        );
    end

    // Select the requested group's result and form the global index.
    always_comb begin
        alloc_avail = 1'b0;
        alloc_vc    = '0;
        for (int v = 0; v < NUM_VNETS; v++) begin
            if (alloc_vnet == VN_W'(v)) begin
                alloc_avail = grp_found[v];
                alloc_vc    = VC_W'(v * VCS_PER_VNET) + VC_W'(grp_idx[v]);
            end
        end
        alloc_grant = alloc_req && alloc_avail;
    end

    // Credit query read-out.
    always_comb begin
        cq_credits = '0;
        for (int i = 0; i < NUM_VCS; i++)
            if (cq_vc == VC_W'(i)) cq_credits = cnt[i];
        cq_has_credit = (cq_credits != '0);
    end

    p_grant_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_grant |-> idle[alloc_vc]);
    p_grant_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_grant && !(credit_valid && credit_free && credit_vc == alloc_vc)
        |=> vc_busy[$past(alloc_vc)]);
    p_no_grant_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req && !alloc_avail |-> !alloc_grant);
    p_release_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        credit_valid && credit_free |=> !vc_busy[$past(credit_vc)]);
endmodule

// File: tb/vc_credit_tracker_tb_top.sv
module vc_credit_tracker_tb_top;
    localparam int NV = 3, VPV = 4, D = 4, NVC = NV * VPV;
    localparam int VC_W = 4, VN_W = 2, CNT_W = 3;

    logic clk = 0, rst_n = 0;
    logic alloc_req = 0, alloc_avail, alloc_grant;
    logic [VN_W-1:0] alloc_vnet = 0;
    logic [VC_W-1:0] alloc_vc, send_vc = 0, credit_vc = 0, cq_vc = 0;
    logic send_valid = 0, credit_valid = 0, credit_free = 0;
    logic [CNT_W-1:0] cq_credits;
    logic cq_has_credit;
    logic [NVC-1:0] vc_busy;

    int m_busy [NVC];
    int m_cnt  [NVC];
    int n_tests = 0, n_fail = 0;

    always #5 clk = ~clk;

    vc_credit_tracker #(.NUM_VNETS(NV), .VCS_PER_VNET(VPV), .BUF_DEPTH(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_vnet(alloc_vnet),
        .alloc_avail(alloc_avail), .alloc_grant(alloc_grant), .alloc_vc(alloc_vc),
        .send_valid(send_valid), .send_vc(send_vc), .credit_valid(credit_valid),
        .credit_vc(credit_vc), .credit_free(credit_free), .cq_vc(cq_vc),
        .cq_credits(cq_credits), .cq_has_credit(cq_has_credit), .vc_busy(vc_busy));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int f_pick(input int vn);
        for (int i = 0; i < VPV; i++)
            if (m_busy[vn*VPV+i] == 0) return vn*VPV + i;
        return -1;
    endfunction

    function automatic int f_busy_vec();
        int r = 0;
        for (int i = 0; i < NVC; i++) r |= (m_busy[i] << i);
        return r;
    endfunction

    // One cycle: drive at negedge, check grant, advance model, check state.
    task automatic step(input bit rq, input int vn, input bit sv, input int svc,
                        input bit cv, input int cvc, input bit cf, input int q);
        int p;
        alloc_req = rq; alloc_vnet = VN_W'(vn);
        send_valid = sv; send_vc = VC_W'(svc);
        credit_valid = cv; credit_vc = VC_W'(cvc); credit_free = cf;
        #1;
        p = f_pick(vn);
        chk(alloc_avail == (p >= 0), "R2 avail", alloc_avail, p >= 0);
        chk(alloc_grant == (rq && p >= 0), "R3/R4 grant", alloc_grant, rq && p >= 0);
        if (rq && p >= 0) chk(alloc_vc == p, "R3 lowest vc", alloc_vc, p);
        if (rq && p >= 0) m_busy[p] = 1;
        if (cv && cf) m_busy[cvc] = 0;
        if (cv) m_cnt[cvc]++;
        if (sv) m_cnt[svc]--;
        @(posedge clk);
        @(negedge clk);
        alloc_req = 0; send_valid = 0; credit_valid = 0; credit_free = 0;
        cq_vc = VC_W'(q);
        #1;
        chk(vc_busy == NVC'(f_busy_vec()), "R3/R7/R9 busy", vc_busy, f_busy_vec());
        chk(cq_credits == m_cnt[q], "R5/R6/R10 count", cq_credits, m_cnt[q]);
        chk(cq_has_credit == (m_cnt[q] != 0), "R8 has_credit", cq_has_credit, m_cnt[q] != 0);
    endtask

    initial begin
        #1_000_000;
        chk(0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int seed = 32'h5eed;
        void'($urandom(seed));
        for (int i = 0; i < NVC; i++) begin m_busy[i] = 0; m_cnt[i] = D; end
        repeat (3) @(negedge clk);
        // R1: reset state
        #1;
        chk(vc_busy == '0, "R1 busy", vc_busy, 0);
        for (int i = 0; i < NVC; i++) begin
            cq_vc = VC_W'(i); #1;
            chk(cq_credits == D, "R1 credits", cq_credits, D);
        end
        @(negedge clk);
        rst_n = 1;
        // R3/R4: fill vnet 1 in order, then one more request
        for (int k = 0; k < VPV + 1; k++) step(1, 1, 0, 0, 0, 0, 0, 4);
        // R5/R8: drain vc 4 to zero
        for (int k = 0; k < D; k++) step(0, 1, 1, 4, 0, 0, 0, 4);
        // R6: credit without release keeps it busy
        step(0, 1, 0, 0, 1, 4, 0, 4);
        // R7: credit with release frees it
        step(0, 1, 0, 0, 1, 4, 1, 4);
        // R10: send and credit on vc 5 together
        step(0, 1, 1, 5, 0, 0, 0, 5);
        step(0, 1, 1, 5, 1, 5, 0, 5);
        // R9: prepare vc 0 idle with fewer than full credits
        step(1, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 1, 0);
        // R9: grant and release name vc 0 in one cycle; release wins
        step(1, 0, 0, 0, 1, 0, 1, 0);
        chk(vc_busy[0] == 0, "R9 release wins", vc_busy[0], 0);
        // Seeded random mix
        for (int n = 0; n < 400; n++) begin
            bit rq, sv, cv, cf;
            int vn, svc, cvc;
            rq = $urandom_range(0, 1); vn = $urandom_range(0, NV - 1);
            svc = $urandom_range(0, NVC - 1); sv = $urandom_range(0, 1) && m_cnt[svc] > 0;
            cvc = $urandom_range(0, NVC - 1); cv = $urandom_range(0, 1) && m_cnt[cvc] < D;
            cf = $urandom_range(0, 2) == 0;
            step(rq, vn, sv, svc, cv, cvc, cf, $urandom_range(0, NVC - 1));
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule